// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block keeps track of the operating mode of a small microcontroller core. It knows seven modes: three running modes and four halted modes. The running modes are active at full rate, active at reduced rate and subactive, which runs from the slow watch clock. The halted modes are sleep, subsleep, standby and watch. The core raises a one-cycle strobe when it executes its sleep instruction, and the wake-up logic raises a one-cycle strobe when an interrupt arrives. On each strobe the controller picks the next mode. Its choice depends on the mode it is in, on three level inputs (standby enable, low-speed select and timer clock source) and on a small configuration register.

The register holds a direct-transfer enable, a reduced-rate enable, the noise-filter sampling select and the subactive clock divider select. When direct transfer is enabled, a sleep strobe can move the core straight from one running mode to another without passing through a halted mode. The block also turns the two clock-select fields into divide ratios for the clock generator, which lies outside this block.

Top module: `lpm_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 0 and the register reads 8'hE0. `sub_div_o` is 8 and `nf_div_o` is 16. Mode codes are: 0 active full rate, 1 active reduced rate, 2 subactive, 3 sleep, 4 subsleep, 5 standby, 6 watch.
- R2: The register layout is as follows. Bit 0 is direct enable, bit 1 is reduced-rate enable, bit 2 is noise-filter select, and bits 4:3 are the subactive divider select. Bits 4:3 are write-only and read as 0. Bits 7:5 always read as 1. A write takes effect at the edge where `cfg_wr_en` is sampled high.
- R3: With direct transfer off, a sleep strobe in either active mode moves the core to one of three modes at the sampling edge. It goes to sleep (3) when standby enable is 0. It goes to standby (5) when standby enable is 1 and the timer source is 0. It goes to watch (6) when both are 1.
- R4: With direct transfer off, a sleep strobe in subactive goes to subsleep (4) when standby enable is 0. It goes to watch (6) when standby enable and the timer source are both 1. It is ignored when standby enable is 1 and the timer source is 0.
- R5: With direct transfer on, a sleep strobe in an active mode is handled as follows. From full rate it goes to reduced rate when standby=0, reduced-rate enable=1 and low-speed=0. From reduced rate it goes to full rate when standby=0, reduced-rate enable=0 and low-speed=0. From either active mode it goes to subactive when standby=1, timer=1 and low-speed=1.
- R6: With direct transfer on, a sleep strobe in subactive with standby=1, timer=1 and low-speed=0 goes to an active mode. The target is reduced rate when reduced-rate enable is 1 and full rate when it is 0.
- R7: The mode does not change in these cases: a sleep strobe with direct transfer on whose inputs match no combination in R5 or R6, a sleep strobe in a halted mode, or a cycle with no strobe.
- R8: A wake strobe in sleep returns the core to the active mode it left. A wake strobe in subsleep returns it to subactive.
- R9: A wake strobe in standby or in watch goes to subactive when low-speed is 1. When low-speed is 0 it goes to the active mode selected by the reduced-rate enable.
- R10: A wake strobe in a running mode has no effect on the mode.
- R11: `sub_div_o` follows the divider select: 00 gives 8, 01 gives 4, and 1x gives 2.
- R12: `nf_div_o` is 16 when the noise-filter select is 0 and 4 when it is 1.
- R13: When a sleep strobe and a register write are sampled at the same edge, the mode decision uses the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Register write enable |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read-back value |
| stby_en | input | 1 | Standby enable level |
| low_spd | input | 1 | Low-speed select level |
| tmr_src | input | 1 | Timer clock-source level |
| sleep_req | input | 1 | One-cycle sleep-instruction strobe |
| wake_req | input | 1 | One-cycle wake-up interrupt strobe |
| mode_o | output | 3 | Current mode code |
| sub_div_o | output | 4 | Subactive clock divide ratio |
| nf_div_o | output | 5 | Noise-filter sampling divide ratio |

## Verification
Every result is due one rising edge after its cause. The mode register takes its new value at the edge that samples a strobe. The register fields, the read-back value and both divide ratios change at the edge that samples a write, because all outputs come straight from flops. The bench drives inputs on falling edges and advances its behavioural model on rising edges. It compares all four outputs on the next falling edge, so every result is sampled exactly one edge after its stimulus. Same-edge write and sleep cases are placed on purpose to check that the decision uses the older register contents.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    MODE_ACT_HI   = 3'd0,
    MODE_ACT_MED  = 3'd1,
    MODE_SUBACT   = 3'd2,
    MODE_SLEEP    = 3'd3,
    MODE_SUBSLEEP = 3'd4,
    MODE_STANDBY  = 3'd5,
    MODE_WATCH    = 3'd6
  } lpm_mode_e;

  // Field positions inside the configuration register
  localparam int unsigned CFG_DIRECT_BIT = 0;
  localparam int unsigned CFG_MED_BIT    = 1;
  localparam int unsigned CFG_NF_BIT     = 2;
  localparam int unsigned CFG_SUB_LSB    = 3;
  localparam int unsigned CFG_SUB_W      = 2;
  localparam int unsigned CFG_USED_W     = CFG_SUB_LSB + CFG_SUB_W;

  typedef struct packed {
    logic [CFG_SUB_W-1:0] sub_sel;
    logic                 nf_fast;
    logic                 med;
    logic                 direct;
  } lpm_cfg_t;

endpackage

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg
  import lpm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output lpm_cfg_t          cfg_o,
  output logic [DATA_W-1:0] rdata_o
);

  lpm_cfg_t cfg_q;
  lpm_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.direct  = wdata[CFG_DIRECT_BIT];
      cfg_d.med     = wdata[CFG_MED_BIT];
      cfg_d.nf_fast = wdata[CFG_NF_BIT];
      cfg_d.sub_sel = wdata[CFG_SUB_LSB +: CFG_SUB_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  // Unused upper bits read as ones, divider select is write-only
  always_comb begin
    rdata_o                          = '0;
    rdata_o[DATA_W-1:CFG_USED_W]     = '1;
    rdata_o[CFG_DIRECT_BIT]          = cfg_q.direct;
    rdata_o[CFG_MED_BIT]             = cfg_q.med;
    rdata_o[CFG_NF_BIT]              = cfg_q.nf_fast;
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/lpm_clk_sel.sv
module lpm_clk_sel
  import lpm_pkg::*;
#(
  parameter int unsigned SUB_DW   = 4,
  parameter int unsigned NF_DW    = 5,
  parameter int unsigned SUB_SLOW = 8,
  parameter int unsigned SUB_MID  = 4,
  parameter int unsigned SUB_FAST = 2,
  parameter int unsigned NF_SLOW  = 16,
  parameter int unsigned NF_FAST  = 4
) (
  input  logic [CFG_SUB_W-1:0] sub_sel,
  input  logic                 nf_fast,
  output logic [SUB_DW-1:0]    sub_div_o,
  output logic [NF_DW-1:0]     nf_div_o
);

  always_comb begin
    if (sub_sel[CFG_SUB_W-1]) begin
      sub_div_o = SUB_DW'(SUB_FAST);
    end else if (sub_sel[0]) begin
      sub_div_o = SUB_DW'(SUB_MID);
    end else begin
      sub_div_o = SUB_DW'(SUB_SLOW);
    end
  end

  always_comb begin
    nf_div_o = nf_fast ? NF_DW'(NF_FAST) : NF_DW'(NF_SLOW);
  end

endmodule

// File: rtl/lpm_mode_next.sv
module lpm_mode_next
  import lpm_pkg::*;
(
  input  lpm_mode_e cur_mode,
  input  logic      ret_med,
  input  lpm_cfg_t  cfg,
  input  logic      stby_en,
  input  logic      low_spd,
  input  logic      tmr_src,
  input  logic      sleep_req,
  input  logic      wake_req,
  output lpm_mode_e nxt_mode,
  output logic      nxt_ret_med
);

  logic      at_hi;
  lpm_mode_e wake_target;
  logic      sub_ok;

  always_comb begin
    at_hi       = (cur_mode == MODE_ACT_HI);
    sub_ok      = stby_en && tmr_src && low_spd;
    wake_target = low_spd ? MODE_SUBACT : (cfg.med ? MODE_ACT_MED : MODE_ACT_HI);
  end

  always_comb begin
    nxt_mode    = cur_mode;
    nxt_ret_med = ret_med;
    case (cur_mode)
      MODE_ACT_HI, MODE_ACT_MED: begin
        if (sleep_req) begin
          if (cfg.direct) begin
            if (!stby_en && !low_spd && (cfg.med == at_hi)) begin
              nxt_mode = at_hi ? MODE_ACT_MED : MODE_ACT_HI;
            end else if (sub_ok) begin
              nxt_mode = MODE_SUBACT;
            end
          end else if (!stby_en) begin
            nxt_mode    = MODE_SLEEP;
            nxt_ret_med = !at_hi;
          end else if (!tmr_src) begin
            nxt_mode = MODE_STANDBY;
          end else begin
            nxt_mode = MODE_WATCH;
          end
        end
      end
      MODE_SUBACT: begin
        if (sleep_req) begin
          if (cfg.direct) begin
            if (stby_en && tmr_src && !low_spd) begin
              nxt_mode = cfg.med ? MODE_ACT_MED : MODE_ACT_HI;
            end
          end else if (!stby_en) begin
            nxt_mode = MODE_SUBSLEEP;
          end else if (tmr_src) begin
            nxt_mode = MODE_WATCH;
          end
        end
      end
      MODE_SLEEP: begin
        if (wake_req) begin
          nxt_mode = ret_med ? MODE_ACT_MED : MODE_ACT_HI;
        end
      end
      MODE_SUBSLEEP: begin
        if (wake_req) begin
          nxt_mode = MODE_SUBACT;
        end
      end
      MODE_STANDBY, MODE_WATCH: begin
        if (wake_req) begin
          nxt_mode = wake_target;
        end
      end
      default: begin
        nxt_mode = MODE_ACT_HI;
      end
    endcase
  end

endmodule

// File: rtl/lpm_mode_ctrl.sv
module lpm_mode_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SUB_DW      = 4,
  parameter int unsigned NF_DW       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              stby_en,
  input  logic              low_spd,
  input  logic              tmr_src,
  input  logic              sleep_req,
  input  logic              wake_req,
  output logic [2:0]        mode_o,
  output logic [SUB_DW-1:0] sub_div_o,
  output logic [NF_DW-1:0]  nf_div_o
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  lpm_cfg_t  cfg;
  lpm_mode_e mode_q;
  lpm_mode_e mode_d;
  logic      ret_med_q;
  logic      ret_med_d;
  logic      mode_en;

  lpm_cfg_reg #(
    .DATA_W (DATA_W)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (cfg_wr_en),
    .wdata   (cfg_wdata),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata)
  );

  lpm_mode_next u_next (
    .cur_mode    (mode_q),
    .ret_med     (ret_med_q),
    .cfg         (cfg),
    .stby_en     (stby_en),
    .low_spd     (low_spd),
    .tmr_src     (tmr_src),
    .sleep_req   (sleep_req),
    .wake_req    (wake_req),
    .nxt_mode    (mode_d),
    .nxt_ret_med (ret_med_d)
  );

  lpm_clk_sel #(
    .SUB_DW (SUB_DW),
    .NF_DW  (NF_DW)
  ) u_clk (
    .sub_sel   (cfg.sub_sel),
    .nf_fast   (cfg.nf_fast),
    .sub_div_o (sub_div_o),
    .nf_div_o  (nf_div_o)
  );

  always_comb begin
    mode_en = (mode_d != mode_q) || (ret_med_d != ret_med_q);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q    <= MODE_ACT_HI;
      ret_med_q <= 1'b0;
    end else if (mode_en) begin
      mode_q    <= mode_d;
      ret_med_q <= ret_med_d;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/lpm_mode_ctrl_chk.sv
module lpm_mode_ctrl_chk
  import lpm_pkg::*;
#(
  parameter int unsigned SUB_DW = 4,
  parameter int unsigned NF_DW  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_req,
  input logic              wake_req,
  input logic [2:0]        mode_o,
  input logic [SUB_DW-1:0] sub_div_o,
  input logic [NF_DW-1:0]  nf_div_o
);

  logic running;
  logic halted;

  always_comb begin
    running = (mode_o == MODE_ACT_HI) || (mode_o == MODE_ACT_MED) || (mode_o == MODE_SUBACT);
    halted  = (mode_o == MODE_SLEEP) || (mode_o == MODE_SUBSLEEP) ||
              (mode_o == MODE_STANDBY) || (mode_o == MODE_WATCH);
  end

  assert_no_strobe_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_req && !wake_req) |=> $stable(mode_o));

  assert_halted_ignores_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wake_req) |=> $stable(mode_o));

  assert_running_ignores_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !sleep_req) |=> $stable(mode_o));

  assert_subsleep_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_SUBSLEEP && wake_req) |=> (mode_o == MODE_SUBACT));

  assert_sleep_wake_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_SLEEP && wake_req) |=> (mode_o == MODE_ACT_HI || mode_o == MODE_ACT_MED));

  assert_deep_wake_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == MODE_STANDBY || mode_o == MODE_WATCH) && wake_req) |=> running);

  assert_sub_div_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sub_div_o) && (sub_div_o >= SUB_DW'(2)) && (sub_div_o <= SUB_DW'(8)));

  assert_nf_div_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (nf_div_o == NF_DW'(16)) || (nf_div_o == NF_DW'(4)));

endmodule

bind lpm_mode_ctrl lpm_mode_ctrl_chk #(
  .SUB_DW (SUB_DW),
  .NF_DW  (NF_DW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep_req (sleep_req),
  .wake_req  (wake_req),
  .mode_o    (mode_o),
  .sub_div_o (sub_div_o),
  .nf_div_o  (nf_div_o)
);

// File: tb/lpm_mode_ctrl_test.sv
`timescale 1ns/1ps
module lpm_mode_ctrl_test;

  localparam int M_HI = 0, M_MED = 1, M_SUB = 2, M_SLP = 3, M_SSLP = 4, M_STBY = 5, M_WTCH = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       stby_en = 1'b0, low_spd = 1'b0, tmr_src = 1'b0;
  logic       sleep_req = 1'b0, wake_req = 1'b0;
  logic [2:0] mode_o;
  logic [3:0] sub_div_o;
  logic [4:0] nf_div_o;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  string phase = "R1";

  // behavioural reference state
  int m_mode, m_ret, m_dir, m_med, m_nf, m_sub;

  always #2 clk = ~clk;

  lpm_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .stby_en(stby_en), .low_spd(low_spd), .tmr_src(tmr_src),
    .sleep_req(sleep_req), .wake_req(wake_req), .mode_o(mode_o),
    .sub_div_o(sub_div_o), .nf_div_o(nf_div_o)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int active_pick();
    return (m_med != 0) ? M_MED : M_HI;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = M_HI; m_ret = 0; m_dir = 0; m_med = 0; m_nf = 0; m_sub = 0;
    end else begin
      int nm;
      nm = m_mode;
      if (sleep_req && (m_mode == M_HI || m_mode == M_MED)) begin
        if (m_dir != 0) begin
          if (m_mode == M_HI && !stby_en && m_med != 0 && !low_spd) nm = M_MED;
          else if (m_mode == M_MED && !stby_en && m_med == 0 && !low_spd) nm = M_HI;
          else if (stby_en && tmr_src && low_spd) nm = M_SUB;
        end else if (!stby_en) begin
          m_ret = m_mode; nm = M_SLP;
        end else nm = tmr_src ? M_WTCH : M_STBY;
      end else if (sleep_req && m_mode == M_SUB) begin
        if (m_dir != 0) begin
          if (stby_en && tmr_src && !low_spd) nm = active_pick();
        end else if (!stby_en) nm = M_SSLP;
        else if (tmr_src) nm = M_WTCH;
      end else if (wake_req) begin
        if (m_mode == M_SLP) nm = m_ret;
        else if (m_mode == M_SSLP) nm = M_SUB;
        else if (m_mode == M_STBY || m_mode == M_WTCH) nm = low_spd ? M_SUB : active_pick();
      end
      m_mode = nm;
      if (cfg_wr_en) begin
        m_dir = cfg_wdata[0]; m_med = cfg_wdata[1]; m_nf = cfg_wdata[2]; m_sub = cfg_wdata[4:3];
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(mode_o, m_mode, {phase, " mode"});
      chk(cfg_rdata, 8'hE0 | (m_nf << 2) | (m_med << 1) | m_dir, {phase, " rdata"});
      chk(sub_div_o, (m_sub >= 2) ? 2 : ((m_sub == 1) ? 4 : 8), {phase, " sub_div"});
      chk(nf_div_o, (m_nf != 0) ? 4 : 16, {phase, " nf_div"});
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        finish_run();
      end
    end
  end

  // one stimulus cycle: drive at falling edge, result visible at next falling edge
  task automatic step(input bit wr, input logic [7:0] wd, input bit sb, input bit ls,
                      input bit tm, input bit slp, input bit wk);
    cfg_wr_en = wr; cfg_wdata = wd; stby_en = sb; low_spd = ls; tmr_src = tm;
    sleep_req = slp; wake_req = wk;
    @(negedge clk);
    cfg_wr_en = 1'b0; sleep_req = 1'b0; wake_req = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d); step(1, d, 0, 0, 0, 0, 0); endtask
  task automatic slp(input bit sb, input bit ls, input bit tm); step(0, 0, sb, ls, tm, 1, 0); endtask
  task automatic wk(input bit ls); step(0, 0, 0, ls, 0, 0, 1); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;
    // R1 reset state
    chk(mode_o, 0, "R1 reset mode"); chk(cfg_rdata, 8'hE0, "R1 reset rdata");
    chk(sub_div_o, 8, "R1 reset sub_div"); chk(nf_div_o, 16, "R1 reset nf_div");

    phase = "R2";
    wr(8'hFF); chk(cfg_rdata, 8'hE7, "R2 readback all ones");
    chk(sub_div_o, 2, "R11 sel 11"); chk(nf_div_o, 4, "R12 fast filter");
    phase = "R11";
    wr(8'h08); chk(sub_div_o, 4, "R11 sel 01"); chk(cfg_rdata, 8'hE0, "R2 write-only bits");
    wr(8'h10); chk(sub_div_o, 2, "R11 sel 10");
    wr(8'h00); chk(sub_div_o, 8, "R11 sel 00"); chk(nf_div_o, 16, "R12 slow filter");

    phase = "R3";
    slp(0, 0, 0); chk(mode_o, M_SLP, "R3 sleep from full rate");
    phase = "R10"; slp(0, 0, 0); chk(mode_o, M_SLP, "R7 sleep in sleep ignored");
    phase = "R8"; wk(0); chk(mode_o, M_HI, "R8 wake back to full rate");
    wk(0); chk(mode_o, M_HI, "R10 wake in running ignored");
    phase = "R5"; wr(8'h03); slp(0, 0, 0); chk(mode_o, M_MED, "R5 direct full to reduced");
    phase = "R3"; wr(8'h02); slp(0, 0, 0); chk(mode_o, M_SLP, "R3 sleep from reduced");
    phase = "R8"; wk(1); chk(mode_o, M_MED, "R8 wake back to reduced");
    phase = "R3"; slp(1, 0, 0); chk(mode_o, M_STBY, "R3 standby");
    phase = "R7"; slp(1, 0, 1); chk(mode_o, M_STBY, "R7 sleep in standby ignored");
    phase = "R9"; wk(0); chk(mode_o, M_MED, "R9 standby wake reduced");
    phase = "R3"; slp(1, 0, 1); chk(mode_o, M_WTCH, "R3 watch");
    phase = "R9"; wk(1); chk(mode_o, M_SUB, "R9 watch wake subactive");
    phase = "R4"; slp(1, 0, 0); chk(mode_o, M_SUB, "R4 subactive standby ignored");
    slp(0, 0, 0); chk(mode_o, M_SSLP, "R4 subsleep");
    phase = "R8"; wk(0); chk(mode_o, M_SUB, "R8 subsleep wake");
    phase = "R4"; slp(1, 0, 1); chk(mode_o, M_WTCH, "R4 watch from subactive");
    phase = "R9"; wk(0); chk(mode_o, M_MED, "R9 watch wake reduced");

    phase = "R5"; wr(8'h01);
    slp(0, 0, 0); chk(mode_o, M_HI, "R5 direct reduced to full");
    phase = "R7"; slp(1, 1, 0); chk(mode_o, M_HI, "R7 unmatched direct ignored");
    phase = "R5"; slp(1, 1, 1); chk(mode_o, M_SUB, "R5 direct to subactive");
    phase = "R6"; slp(1, 0, 1); chk(mode_o, M_HI, "R6 direct sub to full");
    slp(1, 1, 1); wr(8'h03);
    slp(1, 0, 1); chk(mode_o, M_MED, "R6 direct sub to reduced");
    phase = "R10"; wk(0); chk(mode_o, M_MED, "R10 wake in reduced ignored");
    phase = "R13"; step(1, 8'h01, 0, 0, 0, 1, 0);
    chk(mode_o, M_MED, "R13 decision uses old register");
    slp(0, 0, 0); chk(mode_o, M_HI, "R13 new register used next");

    phase = "R7";
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 15);
      step(r == 0, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           (r >= 1 && r <= 5), (r >= 6 && r <= 9));
    end
    cmp_en = 1'b0;
    done = 1'b1;
    finish_run();
  end

endmodule